// File: doc/BRIEF.md
# Issue Window with Tag Wakeup and Two-Level Select

This block is the scheduling window of an out-of-order core. Renamed instructions come in one per cycle. Each carries two source physical-register tags with a ready flag for each, a destination tag and an opaque payload. The instruction is written into the lowest free slot of a 16-entry window. Up to two result tags are broadcast each cycle. Every waiting operand whose tag equals a broadcast tag becomes ready. The writer of a slot sees the same-cycle broadcasts, so an operand produced in the allocation cycle is not missed.

A slot whose two operands are both ready requests issue. Two functional units of the same type are served by two selectors. Each selector is a tree of small arbiters. Leaf nodes of four inputs pass an any-request signal to a root node, and the root passes grants back down. The root is enabled only while its unit is free, and the lowest-numbered requesting slot wins. The second selector sits after the first. It sees the request vector with the first selector's grant removed. A granted slot is emptied at the same clock edge. The block never wakes operands from the destination tags it issues itself; those tags must come back through the broadcast inputs.

Top module: `iq_wakeup_select`

## Requirements
- R1: After reset the window is empty: neither issue port is valid and `alloc_ready` is high.
- R2: An allocation is written into the lowest-numbered empty slot. An entry allocated with both ready flags set is eligible for issue in the following cycle.
- R3: A broadcast on either lane (`bc_vld` bit k, tag in `bc_tag[k*6 +: 6]`) marks every waiting operand with an equal tag as ready. The entry can issue one cycle after that broadcast.
- R4: An entry with only one operand ready never issues.
- R5: A tag broadcast in the cycle an entry is allocated sets the matching ready flags of the new entry.
- R6: When unit 0 is free, port 0 issues the requesting entry at the lowest slot number.
- R7: While `fu0_free` is low, port 0 issues nothing and the waiting entries are kept.
- R8: When unit 1 is free, port 1 issues the lowest requesting entry other than the one granted on port 0. It never issues the same entry as port 0.
- R9: A granted entry leaves the window at that clock edge, never issues again, and its slot can be reused from the next cycle.
- R10: `alloc_ready` is low while all 16 slots are occupied. An allocation attempted then is dropped and never issues.
- R11: An issued entry's destination tag does not wake any operand. A dependent waits until that tag arrives on a broadcast lane.
- R12: A tag on a broadcast lane whose valid bit is low wakes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_vld | input | 1 | Allocate an instruction this cycle |
| alloc_src1 | input | 6 | First source physical tag |
| alloc_src1_rdy | input | 1 | First source already available |
| alloc_src2 | input | 6 | Second source physical tag |
| alloc_src2_rdy | input | 1 | Second source already available |
| alloc_dst | input | 6 | Destination physical tag |
| alloc_pay | input | 8 | Opaque payload carried to issue |
| alloc_ready | output | 1 | At least one slot is empty |
| bc_vld | input | 2 | Broadcast lane valid bits |
| bc_tag | input | 12 | Broadcast tags, lane k at bits k*6 +: 6 |
| fu0_free | input | 1 | Unit 0 can accept an instruction |
| fu1_free | input | 1 | Unit 1 can accept an instruction |
| iss0_vld | output | 1 | Port 0 issues this cycle |
| iss0_dst | output | 6 | Destination tag of port 0 issue |
| iss0_pay | output | 8 | Payload of port 0 issue |
| iss1_vld | output | 1 | Port 1 issues this cycle |
| iss1_dst | output | 6 | Destination tag of port 1 issue |
| iss1_pay | output | 8 | Payload of port 1 issue |

## Verification
A slot whose ready flag is wrongly set shows up one cycle later as an issue that comes too early or out of order. A flag that is wrongly clear makes an expected issue never appear. A valid bit left set after a grant repeats a payload on the next cycle. A valid bit cleared too early drops a payload, and the bench sees that either at once or when the window is drained. A wrong selector order or a broken mask between the two selectors changes which payload leaves on which port in the same cycle. The reference window in the bench therefore compares both ports and `alloc_ready` in every cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W = 6;
  localparam int PAY_W = 8;
  localparam int BC_N  = 2;

  typedef logic [TAG_W-1:0] ptag_t;
  typedef logic [PAY_W-1:0] pay_t;

  typedef struct packed {
    logic  vld;
    ptag_t src1;
    logic  rdy1;
    ptag_t src2;
    logic  rdy2;
    ptag_t dst;
    pay_t  pay;
  } iq_entry_t;

  // True when any valid broadcast lane carries the queried tag.
  function automatic logic tag_hit(input logic [BC_N-1:0] lane_vld,
                                   input ptag_t [BC_N-1:0] lane_tag,
                                   input ptag_t query);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < BC_N; k++) begin
      if (lane_vld[k] && (lane_tag[k] == query)) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/iq_arb_node.sv
// One arbiter node: lowest input index wins, grant only while enabled.
module iq_arb_node #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  input  logic         en,
  output logic         anyreq,
  output logic [W-1:0] gnt
);
  logic found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && !found) begin
        gnt[i] = en;
        found  = 1'b1;
      end
    end
  end

  assign anyreq = |req;
endmodule

// File: rtl/iq_sel_tree.sv
// Two-level select tree: leaf nodes report any-request upward,
// the root enables one leaf, the enabled leaf grants one slot.
module iq_sel_tree #(
  parameter int N     = 16,
  parameter int FANIN = 4
) (
  input  logic [N-1:0] req,
  input  logic         root_en,
  output logic [N-1:0] gnt,
  output logic         any_req
);
  localparam int NGRP = N / FANIN;

  logic [NGRP-1:0] grp_any;
  logic [NGRP-1:0] grp_en;

  for (genvar g = 0; g < NGRP; g++) begin : g_leaf
    iq_arb_node #(.W(FANIN)) u_leaf (
      .req    (req[g*FANIN +: FANIN]),
      .en     (grp_en[g]),
      .anyreq (grp_any[g]),
      .gnt    (gnt[g*FANIN +: FANIN])
    );
  end

  iq_arb_node #(.W(NGRP)) u_root (
    .req    (grp_any),
    .en     (root_en),
    .anyreq (any_req),
    .gnt    (grp_en)
  );
endmodule

// File: rtl/iq_slot.sv
// One window slot: holds an entry, snoops broadcasts, requests when ready.
module iq_slot
  import iq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  iq_entry_t            wr,
  input  logic                 clr,
  input  logic [BC_N-1:0]      bc_vld,
  input  ptag_t [BC_N-1:0]     bc_tags,
  output iq_entry_t            st,
  output logic                 req
);
  logic wr_hit1, wr_hit2, st_hit1, st_hit2;

  assign wr_hit1 = tag_hit(bc_vld, bc_tags, wr.src1);
  assign wr_hit2 = tag_hit(bc_vld, bc_tags, wr.src2);
  assign st_hit1 = tag_hit(bc_vld, bc_tags, st.src1);
  assign st_hit2 = tag_hit(bc_vld, bc_tags, st.src2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (clr) begin
      st.vld <= 1'b0;
    end else if (we) begin
      st      <= wr;
      st.vld  <= 1'b1;
      st.rdy1 <= wr.rdy1 | wr_hit1;
      st.rdy2 <= wr.rdy2 | wr_hit2;
    end else if (st.vld) begin
      st.rdy1 <= st.rdy1 | st_hit1;
      st.rdy2 <= st.rdy2 | st_hit2;
    end
  end

  assign req = st.vld & st.rdy1 & st.rdy2;
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select
  import iq_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ARB_FANIN   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_vld,
  input  logic [TAG_W-1:0]      alloc_src1,
  input  logic                  alloc_src1_rdy,
  input  logic [TAG_W-1:0]      alloc_src2,
  input  logic                  alloc_src2_rdy,
  input  logic [TAG_W-1:0]      alloc_dst,
  input  logic [PAY_W-1:0]      alloc_pay,
  output logic                  alloc_ready,
  input  logic [BC_N-1:0]       bc_vld,
  input  logic [BC_N*TAG_W-1:0] bc_tag,
  input  logic                  fu0_free,
  input  logic                  fu1_free,
  output logic                  iss0_vld,
  output logic [TAG_W-1:0]      iss0_dst,
  output logic [PAY_W-1:0]      iss0_pay,
  output logic                  iss1_vld,
  output logic [TAG_W-1:0]      iss1_dst,
  output logic [PAY_W-1:0]      iss1_pay
);
  localparam int N = NUM_ENTRIES;

  ptag_t [BC_N-1:0] bc_tags;
  iq_entry_t        alloc_ent;
  iq_entry_t        ent [N];
  logic [N-1:0]     vld_vec;
  logic [N-1:0]     req_vec;
  logic [N-1:0]     alloc_oh;
  logic [N-1:0]     gnt0_vec;
  logic [N-1:0]     gnt1_vec;
  logic [N-1:0]     req1_vec;
  logic             any0, any1;
  iq_entry_t        pick0, pick1;

  for (genvar k = 0; k < BC_N; k++) begin : g_bc
    assign bc_tags[k] = bc_tag[k*TAG_W +: TAG_W];
  end

  always_comb begin
    alloc_ent      = '0;
    alloc_ent.vld  = 1'b1;
    alloc_ent.src1 = alloc_src1;
    alloc_ent.rdy1 = alloc_src1_rdy;
    alloc_ent.src2 = alloc_src2;
    alloc_ent.rdy2 = alloc_src2_rdy;
    alloc_ent.dst  = alloc_dst;
    alloc_ent.pay  = alloc_pay;
  end

  // Free-slot finder reuses the arbiter node: lowest empty slot wins.
  iq_arb_node #(.W(N)) u_free (
    .req    (~vld_vec),
    .en     (alloc_vld),
    .anyreq (alloc_ready),
    .gnt    (alloc_oh)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    iq_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (alloc_oh[i]),
      .wr      (alloc_ent),
      .clr     (gnt0_vec[i] | gnt1_vec[i]),
      .bc_vld  (bc_vld),
      .bc_tags (bc_tags),
      .st      (ent[i]),
      .req     (req_vec[i])
    );
    assign vld_vec[i] = ent[i].vld;
  end

  iq_sel_tree #(.N(N), .FANIN(ARB_FANIN)) u_sel0 (
    .req     (req_vec),
    .root_en (fu0_free),
    .gnt     (gnt0_vec),
    .any_req (any0)
  );

  // Second selector in series: the first grant is masked out.
  assign req1_vec = req_vec & ~gnt0_vec;

  iq_sel_tree #(.N(N), .FANIN(ARB_FANIN)) u_sel1 (
    .req     (req1_vec),
    .root_en (fu1_free),
    .gnt     (gnt1_vec),
    .any_req (any1)
  );

  always_comb begin
    pick0 = '0;
    pick1 = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt0_vec[i]) pick0 = pick0 | ent[i];
      if (gnt1_vec[i]) pick1 = pick1 | ent[i];
    end
  end

  assign iss0_vld = any0 & fu0_free;
  assign iss0_dst = pick0.dst;
  assign iss0_pay = pick0.pay;
  assign iss1_vld = any1 & fu1_free;
  assign iss1_dst = pick1.dst;
  assign iss1_pay = pick1.pay;
endmodule

// File: rtl/iq_ws_checker.sv
module iq_ws_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fu0_free,
  input logic         fu1_free,
  input logic         iss0_vld,
  input logic [N-1:0] req_vec,
  input logic [N-1:0] gnt0_vec,
  input logic [N-1:0] gnt1_vec,
  input logic [N-1:0] vld_vec
);
  AST_GNT0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt0_vec)); // R6
  AST_GNT0_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0_vec != '0) |-> ((req_vec & (gnt0_vec - 1'b1)) == '0)); // R6
  AST_ISS0_WHEN_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (fu0_free && (req_vec != '0)) |-> iss0_vld); // R6
  AST_GNT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt0_vec | gnt1_vec) & ~req_vec) == '0); // R4
  AST_FU0_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !fu0_free |-> (gnt0_vec == '0)); // R7
  AST_FU1_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !fu1_free |-> (gnt1_vec == '0)); // R8
  AST_NO_SHARED_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt0_vec & gnt1_vec) == '0); // R8
  AST_FREE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vld_vec & $past(gnt0_vec | gnt1_vec)) == '0)); // R9
endmodule

bind iq_wakeup_select iq_ws_checker #(.N(NUM_ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fu0_free (fu0_free),
  .fu1_free (fu1_free),
  .iss0_vld (iss0_vld),
  .req_vec  (req_vec),
  .gnt0_vec (gnt0_vec),
  .gnt1_vec (gnt1_vec),
  .vld_vec  (vld_vec)
);

// File: tb/iq_wakeup_select_tb.sv
module iq_wakeup_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_vld = 1'b0;
  logic [5:0] alloc_src1 = '0, alloc_src2 = '0, alloc_dst = '0;
  logic       alloc_src1_rdy = 1'b0, alloc_src2_rdy = 1'b0;
  logic [7:0] alloc_pay = '0;
  logic       alloc_ready;
  logic [1:0] bc_vld = '0;
  logic [5:0] bct0 = '0, bct1 = '0;
  logic       fu0_free = 1'b0, fu1_free = 1'b0;
  logic       iss0_vld, iss1_vld;
  logic [5:0] iss0_dst, iss1_dst;
  logic [7:0] iss0_pay, iss1_pay;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_wakeup_select dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld),
    .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy),
    .alloc_src2(alloc_src2), .alloc_src2_rdy(alloc_src2_rdy),
    .alloc_dst(alloc_dst), .alloc_pay(alloc_pay), .alloc_ready(alloc_ready),
    .bc_vld(bc_vld), .bc_tag({bct1, bct0}),
    .fu0_free(fu0_free), .fu1_free(fu1_free),
    .iss0_vld(iss0_vld), .iss0_dst(iss0_dst), .iss0_pay(iss0_pay),
    .iss1_vld(iss1_vld), .iss1_dst(iss1_dst), .iss1_pay(iss1_pay)
  );

  typedef struct {
    bit         v0;
    logic [5:0] d0;
    logic [7:0] p0;
    bit         v1;
    logic [5:0] d1;
    logic [7:0] p1;
    bit         ar;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  string cur_req = "R1";

  // Reference window
  bit         m_v [NE];
  bit         m_r1[NE], m_r2[NE];
  logic [5:0] m_s1[NE], m_s2[NE], m_d[NE];
  logic [7:0] m_p [NE];

  function automatic bit bhit(logic [5:0] t);
    return (bc_vld[0] && bct0 == t) || (bc_vld[1] && bct1 == t);
  endfunction

  // Driver: record this cycle's expectation, advance the model past the edge.
  task automatic tick();
    exp_t e;
    int g0 = -1, g1 = -1, fr = -1;
    for (int i = 0; i < NE; i++)
      if (m_v[i] && m_r1[i] && m_r2[i] && fu0_free && g0 < 0) g0 = i;
    for (int i = 0; i < NE; i++)
      if (m_v[i] && m_r1[i] && m_r2[i] && i != g0 && fu1_free && g1 < 0) g1 = i;
    for (int i = NE-1; i >= 0; i--) if (!m_v[i]) fr = i;
    e.v0 = (g0 >= 0); e.d0 = (g0 >= 0) ? m_d[g0] : '0; e.p0 = (g0 >= 0) ? m_p[g0] : '0;
    e.v1 = (g1 >= 0); e.d1 = (g1 >= 0) ? m_d[g1] : '0; e.p1 = (g1 >= 0) ? m_p[g1] : '0;
    e.ar = (fr >= 0);
    e.tag = cur_req;
    exp_q.push_back(e);
    if (g0 >= 0) m_v[g0] = 0;
    if (g1 >= 0) m_v[g1] = 0;
    for (int i = 0; i < NE; i++) if (m_v[i]) begin
      m_r1[i] = m_r1[i] | bhit(m_s1[i]);
      m_r2[i] = m_r2[i] | bhit(m_s2[i]);
    end
    if (alloc_vld && fr >= 0) begin
      m_v[fr] = 1; m_s1[fr] = alloc_src1; m_s2[fr] = alloc_src2;
      m_r1[fr] = alloc_src1_rdy | bhit(alloc_src1);
      m_r2[fr] = alloc_src2_rdy | bhit(alloc_src2);
      m_d[fr] = alloc_dst; m_p[fr] = alloc_pay;
    end
    @(negedge clk);
    alloc_vld = 1'b0;
    bc_vld = '0;
  endtask

  task automatic put(input logic [7:0] pay, input logic [5:0] s1, input bit r1,
                     input logic [5:0] s2, input bit r2, input logic [5:0] dst);
    alloc_vld = 1'b1; alloc_pay = pay; alloc_src1 = s1; alloc_src1_rdy = r1;
    alloc_src2 = s2; alloc_src2_rdy = r2; alloc_dst = dst;
  endtask

  task automatic bcast(input int lane, input logic [5:0] t);
    if (lane == 0) begin bc_vld[0] = 1'b1; bct0 = t; end
    else begin bc_vld[1] = 1'b1; bct1 = t; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Monitor: compare outputs with the queued expectation mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (iss0_vld !== e.v0 || (e.v0 && (iss0_pay !== e.p0 || iss0_dst !== e.d0))) begin
          errors++;
          $display("FAIL %s port0: got v=%0d pay=%0d dst=%0d, expected v=%0d pay=%0d dst=%0d",
                   e.tag, iss0_vld, iss0_pay, iss0_dst, e.v0, e.p0, e.d0);
        end
        checks++;
        if (iss1_vld !== e.v1 || (e.v1 && (iss1_pay !== e.p1 || iss1_dst !== e.d1))) begin
          errors++;
          $display("FAIL %s port1: got v=%0d pay=%0d dst=%0d, expected v=%0d pay=%0d dst=%0d",
                   e.tag, iss1_vld, iss1_pay, iss1_dst, e.v1, e.p1, e.d1);
        end
        checks++;
        if (alloc_ready !== e.ar) begin
          errors++;
          $display("FAIL %s alloc_ready: got %0d, expected %0d", e.tag, alloc_ready, e.ar);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pc;
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fu0_free = 1'b1; fu1_free = 1'b1;

    cur_req = "R1"; idle(2);                        // R1 empty after reset

    cur_req = "R2"; put(8'd1, 6'd1, 1, 6'd2, 1, 6'd40); tick(); idle(2);   // R2

    // R12 then R3: lane-invalid tag wakes nothing, valid lane 1 does
    cur_req = "R12"; put(8'd2, 6'd10, 0, 6'd3, 1, 6'd41); tick();
    bc_vld = 2'b00; bct1 = 6'd10; bct0 = 6'd10; tick(); idle(2);
    cur_req = "R3"; bcast(1, 6'd10); tick(); idle(2);

    // R4: one operand woken, the other still waiting
    cur_req = "R4"; put(8'd3, 6'd12, 0, 6'd13, 0, 6'd42); tick();
    bcast(0, 6'd12); tick(); idle(3);
    bcast(0, 6'd13); tick(); idle(2);

    // R5: same-cycle broadcast during allocation
    cur_req = "R5"; put(8'd4, 6'd11, 0, 6'd14, 1, 6'd43); bcast(0, 6'd11); tick(); idle(2);

    // R7 and R6: units busy, four ready entries wait, then lowest wins
    cur_req = "R7"; fu0_free = 0; fu1_free = 0;
    for (int i = 0; i < 4; i++) begin
      put(8'(10 + i), 6'd1, 1, 6'd1, 1, 6'(50 + i)); tick();
    end
    idle(2);
    cur_req = "R6"; fu0_free = 1; tick();
    cur_req = "R8"; fu1_free = 1; tick(); idle(1);
    // R8: port 1 alone takes the lowest when unit 0 is busy
    fu0_free = 0; fu1_free = 0;
    put(8'd20, 6'd1, 1, 6'd1, 1, 6'd5); tick();
    put(8'd21, 6'd1, 1, 6'd1, 1, 6'd6); tick();
    fu1_free = 1; tick(); tick();
    fu0_free = 1;

    // R9: freed slot is reused; the new lower entry wins over a later one
    cur_req = "R9"; fu0_free = 0; fu1_free = 0;
    put(8'd30, 6'd1, 1, 6'd1, 1, 6'd7); tick();
    put(8'd31, 6'd1, 1, 6'd1, 1, 6'd8); tick();
    fu0_free = 1; tick();
    fu0_free = 0; put(8'd32, 6'd1, 1, 6'd1, 1, 6'd9); tick();
    fu0_free = 1; fu1_free = 1; tick(); idle(2);

    // R10: fill all slots, drop the extra allocation, drain
    cur_req = "R10";
    for (int i = 0; i < NE; i++) begin
      put(8'(100 + i), 6'd20, 0, 6'd1, 1, 6'(i)); tick();
    end
    put(8'd99, 6'd1, 1, 6'd1, 1, 6'd63); tick(); idle(1);
    bcast(0, 6'd20); tick(); idle(10);

    // R11: own destination tag does not wake the dependent
    cur_req = "R11";
    put(8'd60, 6'd1, 1, 6'd1, 1, 6'd30); tick();
    put(8'd61, 6'd30, 0, 6'd1, 1, 6'd31); tick(); idle(4);
    bcast(1, 6'd30); tick(); idle(2);

    // Mixed traffic
    cur_req = "R3"; pc = 8'd128;
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 1) == 1) begin
        put(pc, 6'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            6'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)));
        pc = pc + 1'b1;
      end
      if ($urandom_range(0, 2) == 0) bcast(0, 6'($urandom_range(0, 7)));
      if ($urandom_range(0, 2) == 0) bcast(1, 6'($urandom_range(0, 7)));
      fu0_free = ($urandom_range(0, 3) != 0);
      fu1_free = ($urandom_range(0, 3) != 0);
      tick();
    end
    fu0_free = 1; fu1_free = 1;
    for (int t = 0; t < 8; t++) begin bcast(t % 2, 6'(t)); tick(); end
    idle(10);

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule